// File: doc/BRIEF.md
# DDR3 Maintenance Command Sequencer

This block produces every housekeeping command a DDR3 controller needs besides reads and writes. Once the front end signals that the power-up wait is over, it issues one long ZQ calibration and a set number of refreshes, then raises its initialization-complete flag. From then on it keeps a refresh interval timer running and issues a burst of refreshes each time the interval expires. It also serves long and short ZQ calibration whenever the user asks for one, and never on its own. Commands leave through a valid/ready handshake toward the command issue path. Refresh deadlines that pass while that path is stalled are banked in a small saturating counter and paid back later.

Two side functions share the block. A memory reset request of any length produces an active-low reset at least a minimum number of cycles wide. An active-low enable tells the PHY when the DLL delay code may be reloaded. That is allowed only while the read/write datapath has been idle for a set number of cycles and initialization is complete. The enable closes in the same cycle that the datapath turns busy.

Top module: `ddr3_maint_seq`

## Requirements
- R1: No command is offered before `init_go` has been seen high. After it, the accepted commands are exactly one ZQCL followed by INIT_REFS refreshes, and only then does `init_done` go high.
- R2: After `init_done`, a refresh occasion falls once every TREFI_CYC cycles, about TREFI_CYC cycles after `init_done` rises. Each occasion yields exactly REF_BURST refresh commands.
- R3: After a command is accepted, the next one is offered no earlier than CMD_GAP+1 cycles later. With `cmd_ready` held high, commands within a burst are accepted exactly CMD_GAP+2 cycles apart.
- R4: Without user requests, no ZQ calibration command is ever issued after initialization.
- R5: `cmd_type` codes are 0 = refresh, 1 = ZQ long (ZQCL), 2 = ZQ short (ZQCS). A `zq_long_req` pulse yields exactly one code 1 command and a `zq_short_req` pulse exactly one code 2 command. When both are pending, the long one goes first.
- R6: A refresh that is due or in progress is served before a pending ZQ request. A ZQ command is offered only after every owed refresh burst has been fully issued.
- R7: Once `cmd_valid` is high it stays high, with `cmd_type` unchanged, until a cycle in which `cmd_ready` is high.
- R8: Refresh deadlines missed under back-pressure are banked, up to MAX_DEBT, on top of the burst already waiting at the port. Deadlines beyond that limit are dropped.
- R9: A `mem_rst_req` held for L cycles drives `mem_rst_n` low for exactly L+RST_MIN_CYC-1 cycles, starting one cycle after the request. This is never fewer than RST_MIN_CYC cycles.
- R10: `dll_upd_n` is low only when `init_done` is high, `dp_busy` is low in the current cycle, and `dp_busy` was low in each of the previous IDLE_GAP cycles. Otherwise it is high.
- R11: Out of reset `cmd_valid` and `init_done` are low, and `mem_rst_n` and `dll_upd_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| init_go | input | 1 | Power-up wait over; start the initialization sequence |
| zq_long_req | input | 1 | Pulse: request one ZQ long calibration |
| zq_short_req | input | 1 | Pulse: request one ZQ short calibration |
| dp_busy | input | 1 | Read or write transfer in progress |
| mem_rst_req | input | 1 | Request to reset the memory devices |
| cmd_ready | input | 1 | Command issue path accepts the offered command |
| cmd_valid | output | 1 | A maintenance command is offered |
| cmd_type | output | 2 | Offered command code (0 refresh, 1 ZQCL, 2 ZQCS) |
| init_done | output | 1 | Initialization sequence complete |
| mem_rst_n | output | 1 | Active-low reset to the memory devices |
| dll_upd_n | output | 1 | Active-low permission to reload the DLL delay code |

## Verification
The assertions assume that `cmd_ready` is only meaningful while `cmd_valid` is high, and that requests arrive as single-cycle pulses. They also assume the refresh interval is long enough for a full burst, which elaboration enforces. The stimulus meets these conditions: it drives every input one time unit after the rising edge and pulses the ZQ requests for exactly one cycle. It raises a new ZQ request only after the previous one has been accepted, so two requests of the same kind are never merged. Back-pressure windows are opened and closed at mid-interval points, so each stall spans a known number of refresh deadlines.

// File: rtl/mnt_pkg.sv
package mnt_pkg;

   typedef enum logic [1:0] {
      MCMD_REF = 2'd0,
      MCMD_ZQL = 2'd1,
      MCMD_ZQS = 2'd2
   } mcmd_e;

   typedef enum logic [1:0] {
      PH_PRE  = 2'd0,
      PH_ZQ   = 2'd1,
      PH_IREF = 2'd2,
      PH_RUN  = 2'd3
   } phase_e;

endpackage

// File: rtl/mnt_ref_timer.sv
module mnt_ref_timer #(
   parameter int TREFI_CYC = 3120,
   parameter int MAX_DEBT  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic take_i,
   output logic debt_nz_o
);
   localparam int TW = (TREFI_CYC > 1) ? $clog2(TREFI_CYC) : 1;
   localparam int DW = $clog2(MAX_DEBT + 1);

   logic [TW-1:0] cnt;
   logic [DW-1:0] debt;
   logic          due;

   assign due       = run_i && (cnt == TW'(TREFI_CYC - 1));
   assign debt_nz_o = (debt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (run_i) begin
         if (due) cnt <= '0;
         else     cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt <= '0;
      end else begin
         case ({due, take_i})
            2'b10:   if (debt != DW'(MAX_DEBT)) debt <= debt + 1'b1;
            2'b01:   if (debt != '0) debt <= debt - 1'b1;
            default: debt <= debt;
         endcase
      end
   end

   // R8: banked deadlines never exceed the configured ceiling
   a_r8_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= DW'(MAX_DEBT));

   // R8: a burst is only started against a banked deadline
   a_r8_take_owed: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> debt != '0);

endmodule

// File: rtl/mnt_rst_stretch.sv
module mnt_rst_stretch #(
   parameter int RST_MIN_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic mem_rst_n_o
);
   localparam int CW = $clog2(RST_MIN_CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (req_i)        cnt <= CW'(RST_MIN_CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign mem_rst_n_o = (cnt == '0);

   // width tracker used only by the check below
   logic [CW-1:0] low_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              low_len <= '0;
      else if (mem_rst_n_o)                    low_len <= '0;
      else if (low_len != CW'(RST_MIN_CYC))    low_len <= low_len + 1'b1;
   end

   // R9: every low pulse on the memory reset lasts the minimum width
   a_r9_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rst_n_o) |-> low_len == CW'(RST_MIN_CYC));

endmodule

// File: rtl/mnt_sched.sv
module mnt_sched
   import mnt_pkg::*;
#(
   parameter int INIT_REFS     = 2,
   parameter int REF_BURST     = 4,
   parameter int CMD_GAP       = 43,
   parameter bit ZQ_LONG_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_go_i,
   input  logic       zql_req_i,
   input  logic       zqs_req_i,
   input  logic       debt_nz_i,
   input  logic       cmd_ready_i,
   output logic       cmd_valid_o,
   output logic [1:0] cmd_type_o,
   output logic       take_o,
   output logic       init_done_o
);
   localparam int MAXR = (REF_BURST > INIT_REFS) ? REF_BURST : INIT_REFS;
   localparam int RW   = $clog2(MAXR + 1);
   localparam int GW   = $clog2(CMD_GAP + 1);

   phase_e        ph, ph_n;
   mcmd_e         tq, ltype;
   logic          vq;
   logic [GW-1:0] gap;
   logic [RW-1:0] rl, rl_n;
   logic          pl, ps;
   logic          pick_l, pick_s;
   logic          clr_l, clr_s;
   logic          launch, slot;

   generate
      if (ZQ_LONG_FIRST) begin : g_long_first
         assign pick_l = pl;
         assign pick_s = ps & ~pl;
      end else begin : g_short_first
         assign pick_s = ps;
         assign pick_l = pl & ~ps;
      end
   endgenerate

   assign slot = !vq && (gap == '0);

   always_comb begin
      launch = 1'b0;
      ltype  = MCMD_REF;
      take_o = 1'b0;
      ph_n   = ph;
      rl_n   = rl;
      clr_l  = 1'b0;
      clr_s  = 1'b0;
      if (slot) begin
         case (ph)
            PH_PRE: if (init_go_i) begin
               launch = 1'b1;
               ltype  = MCMD_ZQL;
               ph_n   = PH_ZQ;
            end
            PH_ZQ: begin
               launch = 1'b1;
               rl_n   = RW'(INIT_REFS - 1);
               ph_n   = PH_IREF;
            end
            PH_IREF: begin
               if (rl != '0) begin
                  launch = 1'b1;
                  rl_n   = rl - 1'b1;
               end else begin
                  ph_n = PH_RUN;
               end
            end
            default: begin
               if (rl != '0) begin
                  launch = 1'b1;
                  rl_n   = rl - 1'b1;
               end else if (debt_nz_i) begin
                  launch = 1'b1;
                  take_o = 1'b1;
                  rl_n   = RW'(REF_BURST - 1);
               end else if (pick_l) begin
                  launch = 1'b1;
                  ltype  = MCMD_ZQL;
                  clr_l  = 1'b1;
               end else if (pick_s) begin
                  launch = 1'b1;
                  ltype  = MCMD_ZQS;
                  clr_s  = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_PRE;
         vq  <= 1'b0;
         tq  <= MCMD_REF;
         gap <= '0;
         rl  <= '0;
         pl  <= 1'b0;
         ps  <= 1'b0;
      end else begin
         ph <= ph_n;
         rl <= rl_n;
         pl <= (pl & ~clr_l) | zql_req_i;
         ps <= (ps & ~clr_s) | zqs_req_i;
         if (launch) begin
            vq <= 1'b1;
            tq <= ltype;
         end else if (vq && cmd_ready_i) begin
            vq  <= 1'b0;
            gap <= GW'(CMD_GAP);
         end else if (gap != '0) begin
            gap <= gap - 1'b1;
         end
      end
   end

   assign cmd_valid_o = vq;
   assign cmd_type_o  = tq;
   assign init_done_o = (ph == PH_RUN);

   // R7: an offered command holds until taken
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      vq && !cmd_ready_i |=> vq && $stable(tq));

   // R6: a ZQ command starts only with no refresh owed or in flight
   a_r6_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vq) && tq != MCMD_REF |-> rl == '0 && !$past(debt_nz_i));

   // R1: the short calibration never appears during initialization
   a_r1_init_types: assert property (@(posedge clk) disable iff (!rst_n)
      vq && ph != PH_RUN |-> tq != MCMD_ZQS);

   // R3: nothing is offered while the spacing counter runs
   a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      vq && !$past(vq) |-> $past(gap) == '0);

endmodule

// File: rtl/ddr3_maint_seq.sv
module ddr3_maint_seq #(
   parameter int TREFI_CYC     = 3120,
   parameter int REF_BURST     = 4,
   parameter int CMD_GAP       = 43,
   parameter int MAX_DEBT      = 8,
   parameter int INIT_REFS     = 2,
   parameter int RST_MIN_CYC   = 40,
   parameter int IDLE_GAP      = 2,
   parameter bit ZQ_LONG_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_go,
   input  logic       zq_long_req,
   input  logic       zq_short_req,
   input  logic       dp_busy,
   input  logic       mem_rst_req,
   input  logic       cmd_ready,
   output logic       cmd_valid,
   output logic [1:0] cmd_type,
   output logic       init_done,
   output logic       mem_rst_n,
   output logic       dll_upd_n
);
   // configuration checks at elaboration
   generate
      if (TREFI_CYC <= REF_BURST * (CMD_GAP + 2)) begin : g_bad_trefi
         $error("refresh interval shorter than one full burst");
      end
      if (REF_BURST < 1 || INIT_REFS < 1 || MAX_DEBT < 1) begin : g_bad_count
         $error("burst, init refresh and debt counts must be at least 1");
      end
      if (CMD_GAP < 1 || RST_MIN_CYC < 1 || IDLE_GAP < 0) begin : g_bad_time
         $error("gap and reset width must be at least 1 cycle");
      end
   endgenerate

   logic debt_nz;
   logic take;

   mnt_ref_timer #(
      .TREFI_CYC (TREFI_CYC),
      .MAX_DEBT  (MAX_DEBT)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (init_done),
      .take_i    (take),
      .debt_nz_o (debt_nz)
   );

   mnt_sched #(
      .INIT_REFS     (INIT_REFS),
      .REF_BURST     (REF_BURST),
      .CMD_GAP       (CMD_GAP),
      .ZQ_LONG_FIRST (ZQ_LONG_FIRST)
   ) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_go_i   (init_go),
      .zql_req_i   (zq_long_req),
      .zqs_req_i   (zq_short_req),
      .debt_nz_i   (debt_nz),
      .cmd_ready_i (cmd_ready),
      .cmd_valid_o (cmd_valid),
      .cmd_type_o  (cmd_type),
      .take_o      (take),
      .init_done_o (init_done)
   );

   mnt_rst_stretch #(
      .RST_MIN_CYC (RST_MIN_CYC)
   ) u_rst (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (mem_rst_req),
      .mem_rst_n_o (mem_rst_n)
   );

   // DLL update window: datapath must have been quiet for IDLE_GAP cycles
   logic quiet;
   generate
      if (IDLE_GAP == 0) begin : g_no_guard
         assign quiet = 1'b1;
      end else begin : g_guard
         localparam int IW = $clog2(IDLE_GAP + 1);
         logic [IW-1:0] idle_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             idle_cnt <= '0;
            else if (dp_busy)                       idle_cnt <= '0;
            else if (idle_cnt != IW'(IDLE_GAP))     idle_cnt <= idle_cnt + 1'b1;
         end
         assign quiet = (idle_cnt == IW'(IDLE_GAP));
      end
   endgenerate

   assign dll_upd_n = ~(init_done & ~dp_busy & quiet);

   // R10: the delay code is frozen whenever a transfer is running
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      dp_busy |-> dll_upd_n);

   // R10: no DLL update before initialization completes
   a_r10_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> dll_upd_n);

   // R10: the window opens only after a quiet cycle on the datapath
   a_r10_quiet_before: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dll_upd_n) |-> !$past(dp_busy) || IDLE_GAP == 0);

endmodule

// File: tb/sim_ddr3_maint_seq.sv
`timescale 1ns/1ps
module sim_ddr3_maint_seq;
   localparam int TREFI = 300;
   localparam int BURST = 4;
   localparam int GAP   = 3;
   localparam int MAXD  = 4;
   localparam int IREFS = 2;
   localparam int RMIN  = 8;
   localparam int IGAP  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_go = 1'b0, zq_long_req = 1'b0, zq_short_req = 1'b0;
   logic dp_busy = 1'b0, mem_rst_req = 1'b0, cmd_ready = 1'b0;
   logic cmd_valid, init_done, mem_rst_n, dll_upd_n;
   logic [1:0] cmd_type;

   ddr3_maint_seq #(
      .TREFI_CYC(TREFI), .REF_BURST(BURST), .CMD_GAP(GAP), .MAX_DEBT(MAXD),
      .INIT_REFS(IREFS), .RST_MIN_CYC(RMIN), .IDLE_GAP(IGAP), .ZQ_LONG_FIRST(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .init_go(init_go), .zq_long_req(zq_long_req),
      .zq_short_req(zq_short_req), .dp_busy(dp_busy), .mem_rst_req(mem_rst_req),
      .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
      .init_done(init_done), .mem_rst_n(mem_rst_n), .dll_upd_n(dll_upd_n)
   );

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0, errors = 0, cyc = 0;
   int acc_t [1024];
   int acc_c [1024];
   int nacc = 0;
   bit pv = 0, pr = 0;
   int ptype = 0;
   int bz = 0, low_run = 0, last_low = 0;
   bit busy_en = 0, rand_rst_chk = 0, done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int count_type(input int from, input int upto, input int ty);
      int c = 0;
      for (int i = from; i < upto; i++) if (acc_t[i] == ty) c++;
      return c;
   endfunction

   function automatic int exp_dll(input bit idone, input bit busy, input int qlen);
      return (idone && !busy && qlen >= IGAP) ? 0 : 1;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         bz = 0; pv = 0; pr = 0; low_run = 0;
      end else begin
         if (pv && !pr)   // R7
            chk(cmd_valid === 1'b1 && int'(cmd_type) == ptype, "R7", int'(cmd_type), ptype);
         if (cmd_valid && cmd_ready && nacc < 1024) begin
            acc_t[nacc] = int'(cmd_type);
            acc_c[nacc] = cyc;
            nacc++;
         end
         pv = cmd_valid; pr = cmd_ready; ptype = int'(cmd_type);
         chk(int'(dll_upd_n) == exp_dll(init_done, dp_busy, bz), "R10",
             int'(dll_upd_n), exp_dll(init_done, dp_busy, bz));
         if (dp_busy) bz = 0; else if (bz < IGAP) bz++;
         if (!mem_rst_n) low_run++;
         else if (low_run > 0) begin
            last_low = low_run;
            if (rand_rst_chk) chk(low_run >= RMIN, "R9", low_run, RMIN);
            low_run = 0;
         end
      end
   end

   // datapath activity
   initial begin
      forever begin
         @(posedge clk); #1;
         dp_busy = busy_en ? ($urandom % 3 == 0) : 1'b0;
      end
   end

   task automatic wait_until(input int c);
      while (cyc < c) begin @(posedge clk); #1; end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int t_init, n0, n_init, zl_req, zs_req, r0, rl_len;
      void'($urandom(32'h5eed));
      step(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(cmd_valid == 1'b0, "R11", int'(cmd_valid), 0);
      chk(init_done == 1'b0, "R11", int'(init_done), 0);
      chk(mem_rst_n == 1'b1 && dll_upd_n == 1'b1, "R11", int'({mem_rst_n, dll_upd_n}), 3);
      cmd_ready = 1'b1;
      busy_en = 1'b1;
      step(20);
      chk(nacc == 0, "R1", nacc, 0);   // nothing before init_go
      init_go = 1'b1; step(1); init_go = 1'b0;
      while (!init_done) @(negedge clk);
      t_init = cyc;
      n_init = nacc;
      // R1 init sequence
      chk(nacc == 1 + IREFS, "R1", nacc, 1 + IREFS);
      chk(acc_t[0] == 1, "R1", acc_t[0], 1);
      chk(count_type(1, 1 + IREFS, 0) == IREFS, "R1", count_type(1, 1 + IREFS, 0), IREFS);
      @(posedge clk); #1;

      // R2/R3/R4 three periodic occasions
      wait_until(t_init + 3 * TREFI + TREFI / 2);
      chk(count_type(n_init, nacc, 0) == 3 * BURST, "R2", count_type(n_init, nacc, 0), 3 * BURST);
      chk(nacc - n_init == 3 * BURST, "R4", count_type(n_init, nacc, 1) + count_type(n_init, nacc, 2), 0);
      chk(acc_c[n_init] - t_init >= TREFI - 2 && acc_c[n_init] - t_init <= TREFI + 4,
          "R2", acc_c[n_init] - t_init, TREFI);
      for (int i = 1; i < BURST; i++)
         chk(acc_c[n_init + i] - acc_c[n_init + i - 1] == GAP + 2, "R3",
             acc_c[n_init + i] - acc_c[n_init + i - 1], GAP + 2);
      chk(acc_c[n_init + BURST] - acc_c[n_init] >= TREFI - 2, "R2",
          acc_c[n_init + BURST] - acc_c[n_init], TREFI);

      // R5 both ZQ kinds pending together: long first
      n0 = nacc;
      zq_long_req = 1'b1; zq_short_req = 1'b1; step(1);
      zq_long_req = 1'b0; zq_short_req = 1'b0;
      wait_until(t_init + 3 * TREFI + TREFI / 2 + 60);
      chk(nacc - n0 == 2, "R5", nacc - n0, 2);
      chk(acc_t[n0] == 1, "R5", acc_t[n0], 1);
      chk(acc_t[n0 + 1] == 2, "R5", acc_t[n0 + 1], 2);

      // R6 refresh stalled at the port, ZQ short arrives afterwards
      wait_until(t_init + 4 * TREFI + TREFI / 2);
      n0 = nacc;
      cmd_ready = 1'b0;
      wait_until(t_init + 5 * TREFI + 10);
      zq_short_req = 1'b1; step(1); zq_short_req = 1'b0;
      wait_until(t_init + 5 * TREFI + 20);
      cmd_ready = 1'b1;
      wait_until(t_init + 5 * TREFI + TREFI / 2 - 5);
      chk(nacc - n0 == BURST + 1, "R6", nacc - n0, BURST + 1);
      chk(count_type(n0, n0 + BURST, 0) == BURST, "R6", count_type(n0, n0 + BURST, 0), BURST);
      chk(acc_t[n0 + BURST] == 2, "R6", acc_t[n0 + BURST], 2);

      // R8 three deadlines banked under back-pressure
      wait_until(t_init + 5 * TREFI + TREFI / 2);
      n0 = nacc;
      cmd_ready = 1'b0;
      wait_until(t_init + 8 * TREFI + TREFI / 2);
      cmd_ready = 1'b1;
      wait_until(t_init + 8 * TREFI + TREFI / 2 + 120);
      chk(nacc - n0 == 3 * BURST, "R8", nacc - n0, 3 * BURST);

      // R8 seven deadlines: ceiling drops the excess
      wait_until(t_init + 9 * TREFI + TREFI / 2);
      n0 = nacc;
      cmd_ready = 1'b0;
      wait_until(t_init + 16 * TREFI + TREFI / 2);
      cmd_ready = 1'b1;
      wait_until(t_init + 16 * TREFI + TREFI / 2 + 130);
      chk(nacc - n0 == (1 + MAXD) * BURST, "R8", nacc - n0, (1 + MAXD) * BURST);
      chk(count_type(n0, nacc, 0) == nacc - n0, "R4", nacc - n0 - count_type(n0, nacc, 0), 0);

      // R9 reset stretch
      mem_rst_req = 1'b1; step(1); mem_rst_req = 1'b0;
      step(RMIN + 10);
      chk(last_low == RMIN, "R9", last_low, RMIN);
      rl_len = 5;
      mem_rst_req = 1'b1; step(rl_len); mem_rst_req = 1'b0;
      step(RMIN + 10);
      chk(last_low == rl_len + RMIN - 1, "R9", last_low, rl_len + RMIN - 1);

      // random phase
      r0 = nacc; zl_req = 0; zs_req = 0;
      rand_rst_chk = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         cmd_ready = ($urandom % 10) < 7;
         if ((zl_req == count_type(r0, nacc, 1)) && (zs_req == count_type(r0, nacc, 2))
             && ($urandom % 40 == 0)) begin
            if ($urandom % 2 == 0) begin zq_long_req = 1'b1; zl_req++; end
            else begin zq_short_req = 1'b1; zs_req++; end
         end
         mem_rst_req = ($urandom % 150 == 0);
         step(1);
         zq_long_req = 1'b0; zq_short_req = 1'b0;
      end
      mem_rst_req = 1'b0;
      cmd_ready = 1'b1;
      step(400);
      chk(count_type(r0, nacc, 1) == zl_req, "R5", count_type(r0, nacc, 1), zl_req);
      chk(count_type(r0, nacc, 2) == zs_req, "R5", count_type(r0, nacc, 2), zs_req);
      chk(count_type(r0, nacc, 0) % BURST == 0, "R2", count_type(r0, nacc, 0) % BURST, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule